// File: doc/BRIEF.md
# Sixteen-Bit Add/Subtract Unit with Status and Control Flags

This block is the arithmetic core of a small integer datapath. It adds or subtracts two 16-bit operands, with or without an incoming carry, and gives the result on the same cycle. The six status flags it derives from that operation are carry, auxiliary carry, overflow, sign, zero and parity. They are captured into a flag register on the clock edge when a write enable is high.

A byte mode restricts the operation to the low eight bits of each operand. In that mode every flag is taken from the byte. The high byte of the result passes operand A's high byte through unchanged, so a destination register keeps its upper half.

Three machine-control flags sit beside the status flags but are never written by arithmetic: string direction, interrupt enable and single-step trap. Each has its own set and clear input.

Top module: `alu_flag_unit`

## Requirements
- R1: With `op_sel`=00 (add) the word result is `op_a + op_b` modulo 2^16. With `op_sel`=01 (add with carry) it is `op_a + op_b + carry_in` modulo 2^16. The carry flag is the carry out of bit 15.
- R2: With `op_sel`=10 (subtract) the word result is `op_a - op_b` modulo 2^16. With `op_sel`=11 (subtract with borrow) it is `op_a - op_b - carry_in` modulo 2^16. The carry flag is set when the subtraction borrows out of bit 15.
- R3: With `byte_mode`=1 the following hold:
  - `result[7:0]` is the 8-bit add/subtract of the low bytes.
  - `result[15:8]` equals `op_a[15:8]`.
  - Carry, overflow and sign come from bit 7.
  - Zero looks only at `result[7:0]`.
- R4: The auxiliary-carry flag is set when an addition carries out of bit 3, or when a subtraction borrows into bit 3 from bit 4. The incoming carry or borrow counts toward this.
- R5: The overflow flag is set when the exact signed result, taken two's-complement at the active width, falls outside that width's range.
- R6: The sign flag copies the top bit of the active-width result. The zero flag is set when the active-width result is all zeros.
- R7: The parity flag is set when `result[7:0]` holds an even number of ones.
- R8: The status flags load on a rising clock edge only when `flag_we`=1. Otherwise they hold their value.
- R9: Each control flag is handled independently on every rising edge:
  - Its set input forces it to 1. Set wins over clear.
  - Its clear input forces it to 0.
  - With neither input high it holds, whatever the arithmetic inputs and `flag_we` do.
- R10: While `rst_n`=0 all nine flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all flags |
| op_a | input | 16 | First operand, minuend for subtraction |
| op_b | input | 16 | Second operand, subtrahend for subtraction |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| byte_mode | input | 1 | 1 selects the 8-bit operation on the low bytes |
| carry_in | input | 1 | Carry or borrow used by op_sel 01 and 11 |
| flag_we | input | 1 | Loads the status flags on the next edge |
| dir_set | input | 1 | Sets the direction flag |
| dir_clr | input | 1 | Clears the direction flag |
| ien_set | input | 1 | Sets the interrupt-enable flag |
| ien_clr | input | 1 | Clears the interrupt-enable flag |
| trap_set | input | 1 | Sets the trap flag |
| trap_clr | input | 1 | Clears the trap flag |
| result | output | 16 | Combinational result |
| cf | output | 1 | Carry / borrow flag |
| af | output | 1 | Auxiliary carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Even-parity flag |
| df | output | 1 | Direction flag |
| ief | output | 1 | Interrupt-enable flag |
| tf | output | 1 | Trap flag |

## Verification
The only state in the block is the nine flag bits. A wrong status flag shows at the flag ports one edge after the write that caused it, and it stays visible until the next write. The bench therefore compares every flag on every cycle against a behavioural model, so a stale, dropped or mis-held flag is caught within one clock.

Errors in carry handling, borrow polarity or byte/word selection appear directly on `result` in the same cycle. The directed corners sit on the signed limits, the nibble boundary and the byte/word split, and they expose a flag taken from the wrong bit.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  input  logic             byte_mode,
  input  logic             carry_in,
  input  logic             flag_we,
  input  logic             dir_set,
  input  logic             dir_clr,
  input  logic             ien_set,
  input  logic             ien_clr,
  input  logic             trap_set,
  input  logic             trap_clr,
  output logic [WIDTH-1:0] result,
  output logic             cf,
  output logic             af,
  output logic             of,
  output logic             sf,
  output logic             zf,
  output logic             pf,
  output logic             df,
  output logic             ief,
  output logic             tf
);
  localparam int HALF = WIDTH / 2;

  logic             is_sub;
  logic             cterm;
  logic [WIDTH-1:0] b_x;
  logic [WIDTH:0]   wsum;
  logic [HALF:0]    bsum;
  logic             top_r, top_a, top_b;
  logic             cf_n, af_n, of_n, sf_n, zf_n, pf_n;

  assign is_sub = op_sel[1];
  assign cterm  = is_sub ^ (op_sel[0] & carry_in);
  assign b_x    = is_sub ? ~op_b : op_b;
  assign wsum   = {1'b0, op_a} + {1'b0, b_x} + {{WIDTH{1'b0}}, cterm};
  assign bsum   = {1'b0, op_a[HALF-1:0]} + {1'b0, b_x[HALF-1:0]} + {{HALF{1'b0}}, cterm};

  assign result = byte_mode ? {op_a[WIDTH-1:HALF], bsum[HALF-1:0]} : wsum[WIDTH-1:0];

  assign top_r = byte_mode ? bsum[HALF-1] : wsum[WIDTH-1];
  assign top_a = byte_mode ? op_a[HALF-1] : op_a[WIDTH-1];
  assign top_b = byte_mode ? b_x[HALF-1]  : b_x[WIDTH-1];

  assign cf_n = (byte_mode ? bsum[HALF] : wsum[WIDTH]) ^ is_sub;
  assign af_n = op_a[4] ^ op_b[4] ^ result[4];
  assign of_n = (top_a == top_b) && (top_r != top_a);
  assign sf_n = top_r;
  assign zf_n = byte_mode ? (bsum[HALF-1:0] == '0) : (wsum[WIDTH-1:0] == '0);
  assign pf_n = ~^result[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cf, af, of, sf, zf, pf} <= '0;
    end else if (flag_we) begin
      {cf, af, of, sf, zf, pf} <= {cf_n, af_n, of_n, sf_n, zf_n, pf_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df  <= 1'b0;
      ief <= 1'b0;
      tf  <= 1'b0;
    end else begin
      if (dir_set)       df  <= 1'b1;
      else if (dir_clr)  df  <= 1'b0;
      if (ien_set)       ief <= 1'b1;
      else if (ien_clr)  ief <= 1'b0;
      if (trap_set)      tf  <= 1'b1;
      else if (trap_clr) tf  <= 1'b0;
    end
  end

  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({cf, af, of, sf, zf, pf}));

  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_set | dir_clr | ien_set | ien_clr | trap_set | trap_clr) |=> $stable({df, ief, tf}));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_set && dir_clr) |=> df);

  a_r6_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
    zf |-> !sf);

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ({cf, af, of, sf, zf, pf, df, ief, tf} == 9'b0));
endmodule

// File: tb/test_alu_flag_unit.sv
`timescale 1ns/1ps
module test_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [1:0]  op_sel = '0;
  logic        byte_mode = 1'b0, carry_in = 1'b0, flag_we = 1'b0;
  logic        dir_set = 0, dir_clr = 0, ien_set = 0, ien_clr = 0, trap_set = 0, trap_clr = 0;
  logic [15:0] result;
  logic        cf, af, of, sf, zf, pf, df, ief, tf;

  int n_cmp = 0, n_bad = 0;
  bit m_cf, m_af, m_of, m_sf, m_zf, m_pf, m_df, m_if, m_tf;
  bit finished = 0;

  always #10 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .byte_mode(byte_mode), .carry_in(carry_in), .flag_we(flag_we),
    .dir_set(dir_set), .dir_clr(dir_clr), .ien_set(ien_set), .ien_clr(ien_clr),
    .trap_set(trap_set), .trap_clr(trap_clr), .result(result),
    .cf(cf), .af(af), .of(of), .sf(sf), .zf(zf), .pf(pf),
    .df(df), .ief(ief), .tf(tf));

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int e_res;
  bit e_cf, e_af, e_of, e_sf, e_zf, e_pf;

  task automatic model();
    int mask, half, av, bv, c, s, sa, sb, sr, r, lo;
    mask = byte_mode ? 'hFF : 'hFFFF;
    half = byte_mode ? 128 : 32768;
    av = op_a & mask;
    bv = op_b & mask;
    c  = op_sel[0] ? int'(carry_in) : 0;
    sa = (av >= half) ? av - 2*half : av;
    sb = (bv >= half) ? bv - 2*half : bv;
    if (!op_sel[1]) begin
      s = av + bv + c;
      e_cf = (s > mask);
      e_af = ((av & 15) + (bv & 15) + c) > 15;
      sr = sa + sb + c;
    end else begin
      s = av - bv - c;
      e_cf = (s < 0);
      e_af = ((av & 15) - (bv & 15) - c) < 0;
      sr = sa - sb - c;
    end
    r = s & mask;
    e_of = (sr > half - 1) || (sr < -half);
    e_sf = (r >= half);
    e_zf = (r == 0);
    lo = r & 'hFF;
    e_pf = ($countones(lo[7:0]) % 2) == 0;
    e_res = byte_mode ? ((op_a & 'hFF00) | r) : r;
  endtask

  task automatic step();
    string rt;
    #1;
    model();
    rt = byte_mode ? "R3" : (op_sel[1] ? "R2" : "R1");
    chk(rt, int'(result), e_res);
    @(posedge clk);
    if (flag_we) begin
      m_cf = e_cf; m_af = e_af; m_of = e_of; m_sf = e_sf; m_zf = e_zf; m_pf = e_pf;
    end
    if (dir_set) m_df = 1; else if (dir_clr) m_df = 0;
    if (ien_set) m_if = 1; else if (ien_clr) m_if = 0;
    if (trap_set) m_tf = 1; else if (trap_clr) m_tf = 0;
    @(negedge clk);
    chk(flag_we ? (byte_mode ? "R3 carry" : "R1/R2 carry") : "R8 carry", int'(cf), int'(m_cf));
    chk("R4 aux", int'(af), int'(m_af));
    chk("R5 overflow", int'(of), int'(m_of));
    chk("R6 sign", int'(sf), int'(m_sf));
    chk("R6 zero", int'(zf), int'(m_zf));
    chk("R7 parity", int'(pf), int'(m_pf));
    chk("R9 dir", int'(df), int'(m_df));
    chk("R9 ien", int'(ief), int'(m_if));
    chk("R9 trap", int'(tf), int'(m_tf));
  endtask

  task automatic arith(input logic [15:0] a, input logic [15:0] b, input logic [1:0] op,
                       input logic bm, input logic ci, input logic we);
    op_a = a; op_b = b; op_sel = op; byte_mode = bm; carry_in = ci; flag_we = we;
    step();
  endtask

  task automatic ctl(input logic [5:0] v);
    {dir_set, dir_clr, ien_set, ien_clr, trap_set, trap_clr} = v;
    step();
    {dir_set, dir_clr, ien_set, ien_clr, trap_set, trap_clr} = '0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: flags are zero in reset, checked with operands that would set some
    op_a = 16'hFFFF; op_b = 16'h0001; flag_we = 1; dir_set = 1; ien_set = 1; trap_set = 1;
    repeat (3) @(negedge clk);
    chk("R10 status", int'({cf, af, of, sf, zf, pf}), 0);
    chk("R10 control", int'({df, ief, tf}), 0);
    {dir_set, ien_set, trap_set} = '0;
    flag_we = 0;
    rst_n = 1;
    @(negedge clk);

    // R1 / R4 / R5 / R6 / R7 word add corners
    arith(16'h7FFF, 16'h0001, 2'b00, 0, 0, 1);   // signed overflow, aux carry
    arith(16'hFFFF, 16'h0001, 2'b00, 0, 0, 1);   // carry out, zero
    arith(16'h1234, 16'h4321, 2'b01, 0, 1, 1);   // add with carry
    arith(16'h8000, 16'h8000, 2'b00, 0, 0, 1);   // negative overflow
    arith(16'h000F, 16'h0000, 2'b01, 0, 1, 1);   // aux carry from carry_in
    // R2 subtract corners
    arith(16'h0000, 16'h0001, 2'b10, 0, 0, 1);   // borrow, result FFFF
    arith(16'h8000, 16'h0001, 2'b10, 0, 0, 1);   // signed overflow
    arith(16'h0010, 16'h0001, 2'b10, 0, 0, 1);   // nibble borrow
    arith(16'h0005, 16'h0005, 2'b11, 0, 1, 1);   // subtract with borrow
    arith(16'h0005, 16'h0005, 2'b11, 0, 0, 1);   // zero
    // R3 byte mode
    arith(16'hAB7F, 16'h1201, 2'b00, 1, 0, 1);   // byte overflow, high byte kept
    arith(16'h55FF, 16'h0001, 2'b00, 1, 0, 1);   // byte carry, byte zero
    arith(16'h1200, 16'h0001, 2'b10, 1, 0, 1);   // byte borrow
    arith(16'h0080, 16'h0001, 2'b11, 1, 1, 1);   // byte overflow on borrow
    // R8 hold: flags must not change without write enable
    arith(16'h7FFF, 16'h0001, 2'b00, 0, 0, 1);
    arith(16'h0000, 16'h0000, 2'b00, 0, 0, 0);
    chk("R8 hold of", int'(of), 1);
    // R9 control flags
    ctl(6'b100000);
    chk("R9 dir set", int'(df), 1);
    ctl(6'b110000);
    chk("R9 set wins", int'(df), 1);
    ctl(6'b011010);
    ctl(6'b000101);
    arith(16'hFFFF, 16'hFFFF, 2'b00, 0, 1, 1);
    ctl(6'b101010);
    ctl(6'b010101);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      {dir_set, dir_clr, ien_set, ien_clr, trap_set, trap_clr} = 6'($urandom);
      arith(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 4) != 0);
      {dir_set, dir_clr, ien_set, ien_clr, trap_set, trap_clr} = '0;
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule